// File: doc/BRIEF.md
# Absolute-to-physical address mapper

This block produces the physical address for a memory access made while virtual translation is switched off. It takes a 64-bit absolute address, a flag for the wide (64-bit) addressing mode, a flag that selects the newer architecture revision, and the size of the access. From these it forms a 64-bit physical address that is already confined to the implemented physical space of `PA_BITS` bits. It also returns the permission set for the access and a flag that marks a misaligned access.

In wide mode the low `PA_BITS` bits of the address are kept and then sign-extended. In narrow mode on the newer revision, the top nibbles of the low word select one of three regions: ordinary memory, I/O space, or the firmware window. Each region has its own extension rule. The older revision always zero-extends the low word. With translation off, every access is granted read, write and execute.

By default the result passes through one register stage that loads on an input strobe. Setting `REG_OUT` to 0 makes the whole path combinational.

Top module: `abs_phys_map`

## Requirements
- R1: With `wide_mode`=1, `phys_addr` equals `abs_addr[PA_BITS-1:0]` sign-extended from bit `PA_BITS-1` to 64 bits. `new_arch` and `abs_addr[63:PA_BITS]` have no effect.
- R2: With `wide_mode`=0 and `new_arch`=1, when `abs_addr[31:28]` is not 4'hF, `phys_addr` equals `abs_addr[31:0]` zero-extended. Bits 63:32 of the input are ignored.
- R3: With `wide_mode`=0 and `new_arch`=1, when `abs_addr[31:28]`=4'hF and `abs_addr[27:24]`≠0, `phys_addr` equals `abs_addr[31:0]` sign-extended from bit 31.
- R4: With `wide_mode`=0 and `new_arch`=1, when `abs_addr[31:24]`=8'hF0, `phys_addr` equals `abs_addr[31:0]` zero-extended, with every bit from `PA_BITS-4` through 63 then set to one.
- R5: With `wide_mode`=0 and `new_arch`=0, `phys_addr` equals `abs_addr[31:0]` zero-extended, whatever the top nibbles hold.
- R6: Every result carries `perm`=3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute.
- R7: `size_log2` codes the access size as 0=1 byte, 1=2, 2=4 and 3=8 bytes. `unaligned` is 1 exactly when any of the low `size_log2` bits of `abs_addr` is 1.
- R8: With `REG_OUT`=1, each cycle with `in_valid`=1 yields exactly one cycle of `out_valid`=1, one clock later, carrying that request's result.
- R9: After reset, `out_valid`, `phys_addr`, `perm` and `unaligned` are zero. In cycles with `in_valid`=0, the result outputs keep their last value and ignore the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the result stage |
| abs_addr | input | 64 | Absolute address |
| wide_mode | input | 1 | 1 selects wide (64-bit) addressing |
| new_arch | input | 1 | 1 selects the newer revision's region rules |
| size_log2 | input | 2 | log2 of the access size in bytes |
| out_valid | output | 1 | Result valid, one cycle per request |
| phys_addr | output | 64 | Physical address, extended to 64 bits |
| perm | output | 3 | Granted permissions {read, write, execute} |
| unaligned | output | 1 | Misaligned access fault |

## Verification
The region extension and the alignment fault are computed in parallel from the same request, so both can be set in one result. The bench provokes this with firmware-window and older-revision addresses that carry odd low bits together with multi-byte sizes. It then judges the extended address and the fault flag of that single result against a model that is independent of the RTL. Idle gaps with changing inputs also show that the result stage holds its value between requests.

// File: rtl/abs_map_pkg.sv
package abs_map_pkg;
  localparam int unsigned ABS_W  = 64;
  localparam int unsigned PHYS_W = 64;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [1:0] {
    RGN_WIDE = 2'd0,
    RGN_MEM  = 2'd1,
    RGN_IO   = 2'd2,
    RGN_FW   = 2'd3
  } region_e;

  // bit 2 read, bit 1 write, bit 0 execute
  typedef logic [2:0] perm_t;
  localparam perm_t PERM_ALL = 3'b111;

  typedef struct packed {
    logic [PHYS_W-1:0] phys;
    perm_t             perm;
    logic              unaligned;
  } map_res_t;
endpackage

// File: rtl/abs_region_decode.sv
module abs_region_decode
  import abs_map_pkg::*;
(
  input  logic [7:0] hi_byte_i,
  input  logic       wide_i,
  input  logic       new_arch_i,
  output region_e    region_o
);
  logic seg_top_f;
  logic seg_sub_nz;

  always_comb begin
    seg_top_f  = (hi_byte_i[7:4] == 4'hF);
    seg_sub_nz = |hi_byte_i[3:0];
    if (wide_i) begin
      region_o = RGN_WIDE;
    end else if (!new_arch_i || !seg_top_f) begin
      region_o = RGN_MEM;
    end else if (seg_sub_nz) begin
      region_o = RGN_IO;
    end else begin
      region_o = RGN_FW;
    end
  end
endmodule

// File: rtl/abs_extend.sv
module abs_extend
  import abs_map_pkg::*;
#(
  parameter int unsigned PA_BITS = 40
) (
  input  logic [PA_BITS-1:0] addr_lo_i,
  input  region_e            region_i,
  output logic [PHYS_W-1:0]  phys_o
);
  localparam int unsigned EXT_W       = PHYS_W - PA_BITS;
  localparam int unsigned FW_ONES_LSB = PA_BITS - 4;
  localparam logic [PHYS_W-1:0] FW_MASK =
    ~((64'd1 << FW_ONES_LSB) - 64'd1);

  logic [31:0] lo_word;

  always_comb begin
    lo_word = addr_lo_i[31:0];
    unique case (region_i)
      RGN_WIDE: phys_o = {{EXT_W{addr_lo_i[PA_BITS-1]}}, addr_lo_i};
      RGN_MEM:  phys_o = {32'h0, lo_word};
      RGN_IO:   phys_o = {{32{lo_word[31]}}, lo_word};
      RGN_FW:   phys_o = {32'h0, lo_word} | FW_MASK;
      default:  phys_o = '0;
    endcase
  end
endmodule

// File: rtl/abs_align_chk.sv
module abs_align_chk
  import abs_map_pkg::*;
(
  input  logic [2:0]        low_bits_i,
  input  logic [SIZE_W-1:0] size_log2_i,
  output logic              misaligned_o
);
  logic [3:0] span;
  logic [2:0] mask;

  always_comb begin
    span         = 4'd1 << size_log2_i;
    mask         = span[2:0] - 3'd1;
    misaligned_o = |(low_bits_i & mask);
  end
endmodule

// File: rtl/abs_out_stage.sv
module abs_out_stage
  import abs_map_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid_i,
  input  map_res_t res_i,
  output logic     valid_o,
  output map_res_t res_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic     valid_q, valid_d;
      map_res_t res_q, res_d;
      logic     res_en;

      always_comb begin
        res_en  = valid_i;
        valid_d = valid_i;
        res_d   = res_en ? res_i : res_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          res_q   <= '0;
        end else begin
          valid_q <= valid_d;
          res_q   <= res_d;
        end
      end

      assign valid_o = valid_q;
      assign res_o   = res_q;
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign valid_o = valid_i;
      assign res_o   = res_i;
    end
  endgenerate
endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map
  import abs_map_pkg::*;
#(
  parameter int unsigned PA_BITS = 40,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ABS_W-1:0]  abs_addr,
  input  logic              wide_mode,
  input  logic              new_arch,
  input  logic [SIZE_W-1:0] size_log2,
  output logic              out_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [2:0]        perm,
  output logic              unaligned
);
  generate
    if (PA_BITS < 37 || PA_BITS > 54) begin : g_bad_pa_bits
      $error("abs_phys_map: PA_BITS must lie in 37..54");
    end
  endgenerate

  region_e  region;
  logic     misaligned;
  map_res_t res_comb;
  map_res_t res_out;
  logic     unused_hi_bits;

  assign unused_hi_bits = ^abs_addr[ABS_W-1:PA_BITS];

  abs_region_decode u_decode (
    .hi_byte_i  (abs_addr[31:24]),
    .wide_i     (wide_mode),
    .new_arch_i (new_arch),
    .region_o   (region)
  );

  abs_extend #(.PA_BITS(PA_BITS)) u_extend (
    .addr_lo_i (abs_addr[PA_BITS-1:0]),
    .region_i  (region),
    .phys_o    (res_comb.phys)
  );

  abs_align_chk u_align (
    .low_bits_i   (abs_addr[2:0]),
    .size_log2_i  (size_log2),
    .misaligned_o (misaligned)
  );

  assign res_comb.perm      = PERM_ALL;
  assign res_comb.unaligned = misaligned;

  abs_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .res_i   (res_comb),
    .valid_o (out_valid),
    .res_o   (res_out)
  );

  assign phys_addr = res_out.phys;
  assign perm      = res_out.perm;
  assign unaligned = res_out.unaligned;

  generate
    if (REG_OUT) begin : g_chk
      AST_WIDE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode) |=>
          ($countones(phys_addr[PHYS_W-1:PA_BITS-1]) == 0 ||
           &phys_addr[PHYS_W-1:PA_BITS-1])); // R1
      AST_MEM_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && (!new_arch || abs_addr[31:28] != 4'hF)) |=>
          (phys_addr[63:32] == 32'h0)); // R2
      AST_IO_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && new_arch && abs_addr[31:28] == 4'hF &&
         abs_addr[27:24] != 4'h0) |=> (&phys_addr[63:31])); // R3
      AST_FW_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && new_arch && abs_addr[31:24] == 8'hF0) |=>
          (&phys_addr[PHYS_W-1:PA_BITS-4] &&
           phys_addr[PA_BITS-5:32] == '0)); // R4
      AST_PERM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (perm == 3'b111)); // R6
      AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_log2 == 2'd0) |=> !unaligned); // R7
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
      AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(phys_addr) && $stable(unaligned))); // R9
    end
  endgenerate
endmodule

// File: tb/abs_phys_map_test.sv
module abs_phys_map_test;
  localparam int CLK_PERIOD      = 10;
  localparam int PA_BITS         = 40;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] abs_addr;
  logic        wide_mode;
  logic        new_arch;
  logic [1:0]  size_log2;
  logic        out_valid;
  logic [63:0] phys_addr;
  logic [2:0]  perm;
  logic        unaligned;

  abs_phys_map #(.PA_BITS(PA_BITS), .REG_OUT(1'b1)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .abs_addr  (abs_addr),
    .wide_mode (wide_mode),
    .new_arch  (new_arch),
    .size_log2 (size_log2),
    .out_valid (out_valid),
    .phys_addr (phys_addr),
    .perm      (perm),
    .unaligned (unaligned)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_sent   = 0;
  int n_seen   = 0;
  bit done     = 0;

  logic [63:0] q_phys[$];
  bit          q_unal[$];
  string       q_tag[$];
  logic [63:0] last_phys;
  bit          last_unal;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic logic [63:0] model_phys(logic [63:0] a, bit w, bit na);
    logic [63:0] keep;
    logic [63:0] r;
    if (w) begin
      keep = (64'd1 << PA_BITS) - 64'd1;
      r = a & keep;
      if (a[PA_BITS-1]) r = r | ~keep;
    end else if (!na || a[31:28] != 4'hF) begin
      r = a & 64'h0000_0000_FFFF_FFFF;
    end else if (a[27:24] != 4'h0) begin
      r = {32'hFFFF_FFFF, a[31:0]};
    end else begin
      r = (a & 64'h0000_0000_FFFF_FFFF) | ~((64'd1 << (PA_BITS - 4)) - 64'd1);
    end
    return r;
  endfunction

  function automatic string model_tag(logic [63:0] a, bit w, bit na);
    if (w) return "R1";
    if (!na) return "R5";
    if (a[31:28] != 4'hF) return "R2";
    if (a[27:24] != 4'h0) return "R3";
    return "R4";
  endfunction

  function automatic bit model_unal(logic [63:0] a, logic [1:0] sz);
    return (a % (64'd1 << sz)) != 64'd0;
  endfunction

  task automatic send(input logic [63:0] a, input bit w, input bit na,
                      input logic [1:0] sz);
    @(negedge clk);
    abs_addr  = a;
    wide_mode = w;
    new_arch  = na;
    size_log2 = sz;
    in_valid  = 1'b1;
    last_phys = model_phys(a, w, na);
    last_unal = model_unal(a, sz);
    q_phys.push_back(last_phys);
    q_unal.push_back(last_unal);
    q_tag.push_back(model_tag(a, w, na));
    n_sent++;
  endtask

  // Drop the strobe, scramble the inputs, and confirm the result is held (R9)
  task automatic idle_hold(input logic [63:0] junk);
    @(negedge clk);
    in_valid  = 1'b0;
    abs_addr  = junk;
    wide_mode = ~wide_mode;
    size_log2 = 2'd3;
    @(negedge clk);
    abs_addr = ~junk;
    check(out_valid == 1'b0, "R8", "out_valid in idle", {63'd0, out_valid}, 64'd0);
    check(phys_addr == last_phys, "R9", "phys held in idle", phys_addr, last_phys);
    check(unaligned == last_unal, "R9", "unaligned held in idle",
          {63'd0, unaligned}, {63'd0, last_unal});
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        n_seen++;
        if (q_phys.size() == 0) begin
          check(1'b0, "R8", "result with no request", 64'd1, 64'd0);
        end else begin
          logic [63:0] ep;
          bit          eu;
          string       et;
          ep = q_phys.pop_front();
          eu = q_unal.pop_front();
          et = q_tag.pop_front();
          check(phys_addr == ep, et, "phys_addr", phys_addr, ep);
          check(perm == 3'b111, "R6", "perm", {61'd0, perm}, 64'd7);
          check(unaligned == eu, "R7", "unaligned", {63'd0, unaligned}, {63'd0, eu});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      finish_up();
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    abs_addr  = 64'h0;
    wide_mode = 1'b0;
    new_arch  = 1'b0;
    size_log2 = 2'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check(phys_addr == 64'd0, "R9", "reset phys_addr", phys_addr, 64'd0);
    check(perm == 3'd0, "R9", "reset perm", {61'd0, perm}, 64'd0);
    check(unaligned == 1'b0, "R9", "reset unaligned", {63'd0, unaligned}, 64'd0);
    rst_n = 1'b1;

    // R1: wide mode, positive and negative at bit PA_BITS-1
    send(64'hFFFF_0012_3456_7890, 1'b1, 1'b1, 2'd3);
    send(64'h0000_00A5_0000_1000, 1'b1, 1'b0, 2'd2);
    // R2: memory region, high input bits ignored, top nibble E boundary
    send(64'hDEAD_BEEF_1234_5678, 1'b0, 1'b1, 2'd3);
    send(64'h0000_0000_EFFF_FFFF, 1'b0, 1'b1, 2'd0);
    // R3: I/O region, smallest and largest sub-nibble
    send(64'h0000_0000_F100_0004, 1'b0, 1'b1, 2'd2);
    send(64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 1'b1, 2'd3);
    idle_hold(64'h5555_AAAA_F000_0001);
    // R4: firmware window, then with a misaligned halfword in the same result (R7)
    send(64'h1234_0000_F000_0010, 1'b0, 1'b1, 2'd3);
    send(64'h0000_0000_F0FF_FFFB, 1'b0, 1'b1, 2'd1);
    // R5: older revision ignores the region nibbles
    send(64'h0000_0000_F000_0010, 1'b0, 1'b0, 2'd0);
    send(64'hABCD_0000_F300_0006, 1'b0, 1'b0, 2'd3);
    // R7: alignment per size code
    send(64'h0000_0000_0000_1003, 1'b0, 1'b1, 2'd1);
    send(64'h0000_0000_0000_1002, 1'b0, 1'b1, 2'd1);
    send(64'h0000_0000_0000_1004, 1'b0, 1'b1, 2'd3);
    send(64'h0000_0000_0000_1004, 1'b0, 1'b1, 2'd2);
    send(64'h0000_0000_0000_1001, 1'b0, 1'b1, 2'd0);
    send(64'h0000_0080_0000_0007, 1'b1, 1'b1, 2'd3);
    idle_hold(64'h0F0F_0F0F_F0F0_F0F0);

    // R8: every request produced exactly one result
    check(q_phys.size() == 0, "R8", "results outstanding", 64'(q_phys.size()), 64'd0);
    check(n_seen == n_sent, "R8", "result count", 64'(n_seen), 64'(n_sent));
    finish_up();
  end
endmodule